// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives up to four pulse-width modulated pins from one 8-bit up-counter. All pins share the counter, so they all have the same period and start each period together. The counter advances once per prescaled tick, and one period is always 256 ticks long. The only way to change the period is to change the 8-bit prescale value `p`. One period then lasts `256 * (p + 1)` clock cycles. Each channel compares the shared counter with its own duty value `d`. The pin is high while the counter is at or below `d`. So `d = 0` gives a one-tick pulse, and `d = 255` holds the pin high for the whole period.

Software programs the block through a 32-bit register port with word-aligned addresses. A write is taken on a clock edge. A read returns the programmed value combinationally. There is one duty word per channel. A single control word holds the prescale value, split into two nibbles, and one enable bit common to all outputs. New duty and prescale values go first into the programmed registers. They are copied into working copies only at the edge where the counter wraps from 255 to 0, so a running period is never cut short or stretched. While the block is disabled, the working copies follow the programmed registers on every cycle.

Top module: `pwm_bank_top`

## Requirements
- R1: After reset every pin is low, and every register (duty words and control word) reads back as 0.
- R2: Register map. Duty of channel c is at byte address 4*c in bits 7:0. The control word is at byte address 0x50. In the control word, prescale bits 3:0 are in bits 3:0, prescale bits 7:4 are in bits 14:11, and the enable is bit 9. All other bits are ignored on write and read as 0. Unmapped addresses read 0. Reads return the programmed values, not the working copies.
- R3: While enabled with prescale p, every pin that toggles has a period of 256*(p+1) clock cycles.
- R4: With duty d < 255, each high pulse lasts (d+1)*(p+1) cycles. Duty 0 therefore gives p+1 cycles.
- R5: With duty 255 the pin stays high for as long as the block is enabled.
- R6: All toggling pins rise in the same cycle, at counter value 0.
- R7: When the enable is written to 0, all pins are low from the cycle after the write edge, and the counter is cleared. When the enable is written to 1, pins go low-to-high one clock edge after the write edge, starting a period at counter 0.
- R8: A duty write made while running takes effect from the next period boundary. A write that lands exactly on the wrap edge takes effect one period later.
- R9: A prescale write made while running takes effect from the next period boundary. The current period keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (8) | Byte address, bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pwm_o | output | NUM_CH (4) | PWM pins, one per channel |

## Verification
The register write and the period-boundary reload of the working copies can fall on the same clock edge. The bench provokes this by timing a duty write so that its edge is exactly the edge where the counter goes from 255 to 0. It then measures the next two pulses. The first pulse must keep the old width, and the second must carry the new width. Writes in the middle of a period, for both duty and prescale, are judged the same way: the pulse width and period of the current period and of the following one are measured and compared with the widths computed from the old and new values.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned PS_W      = 8;
  localparam int unsigned NIB_W     = PS_W / 2;
  localparam int unsigned PS_LO_LSB = 0;
  localparam int unsigned PS_HI_LSB = 11;
  localparam int unsigned EN_BIT    = 9;
  localparam logic [7:0]  CTRL_OFFS = 8'h50;

  typedef struct packed {
    logic            en;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output ctrl_t                   ctrl_o,
  output logic [NUM_CH*CNT_W-1:0] duty_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CTRL_IDX = WORD_W'(CTRL_OFFS >> 2);

  logic [WORD_W-1:0] widx;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  duty_q [NUM_CH];

  assign widx = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && widx == CTRL_IDX) begin
      ctrl_q.ps <= {wdata_i[PS_HI_LSB +: NIB_W], wdata_i[PS_LO_LSB +: NIB_W]};
      ctrl_q.en <= wdata_i[EN_BIT];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        duty_q[c] <= '0;
      end else if (wr_en_i && widx == WORD_W'(c)) begin
        duty_q[c] <= wdata_i[CNT_W-1:0];
      end
    end
    assign duty_o[c*CNT_W +: CNT_W] = duty_q[c];
  end

  always_comb begin
    rdata_o = '0;
    if (widx == CTRL_IDX) begin
      rdata_o[PS_LO_LSB +: NIB_W] = ctrl_q.ps[NIB_W-1:0];
      rdata_o[PS_HI_LSB +: NIB_W] = ctrl_q.ps[PS_W-1:NIB_W];
      rdata_o[EN_BIT]             = ctrl_q.en;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (widx == WORD_W'(c)) rdata_o[CNT_W-1:0] = duty_q[c];
    end
  end

  assign ctrl_o = ctrl_q;

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i};
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PS_W-1:0]  ps_i,
  output logic             active_o,
  output logic             load_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PS_W-1:0]  ps_act_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             run_q;
  logic [PS_W-1:0]  pdiv_q;
  logic [PS_W-1:0]  ps_act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active, tick, wrap;

  // run_q delays start by one edge so working copies see same-edge writes
  assign active = en_i & run_q;
  assign tick   = (pdiv_q == ps_act_q);
  assign wrap   = tick & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pdiv_q   <= '0;
      cnt_q    <= '0;
      ps_act_q <= '0;
    end else begin
      run_q <= en_i;
      if (!active) begin
        pdiv_q   <= '0;
        cnt_q    <= '0;
        ps_act_q <= ps_i;
      end else if (tick) begin
        pdiv_q <= '0;
        cnt_q  <= cnt_q + 1'b1;
        if (wrap) ps_act_q <= ps_i;
      end else begin
        pdiv_q <= pdiv_q + 1'b1;
      end
    end
  end

  assign active_o = active;
  assign load_o   = ~active | wrap;
  assign cnt_o    = cnt_q;
  assign ps_act_o = ps_act_q;
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             load_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] duty_act_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] duty_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_act_q <= '0;
    else if (load_i) duty_act_q <= duty_i;
  end

  assign pwm_o      = active_i & (cnt_i <= duty_act_q);
  assign duty_act_o = duty_act_q;
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  ctrl_t                   ctrl;
  logic                    run_en;
  logic [PS_W-1:0]         prog_ps;
  logic [NUM_CH*CNT_W-1:0] duty_prog;
  logic [NUM_CH*CNT_W-1:0] duty_act;
  logic                    active, load;
  logic [CNT_W-1:0]        cnt;
  logic [PS_W-1:0]         ps_act;

  pwm_bank_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl),
    .duty_o  (duty_prog)
  );

  assign run_en  = ctrl.en;
  assign prog_ps = ctrl.ps;

  pwm_bank_timebase #(
    .CNT_W (CNT_W),
    .PS_W  (PS_W)
  ) tb_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (run_en),
    .ps_i     (prog_ps),
    .active_o (active),
    .load_o   (load),
    .cnt_o    (cnt),
    .ps_act_o (ps_act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_chan #(
      .CNT_W (CNT_W)
    ) ch_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .duty_i     (duty_prog[c*CNT_W +: CNT_W]),
      .load_i     (load),
      .active_i   (active),
      .cnt_i      (cnt),
      .duty_act_o (duty_act[c*CNT_W +: CNT_W]),
      .pwm_o      (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PS_W   = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    active_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [PS_W-1:0]         ps_act_i,
  input logic [NUM_CH*CNT_W-1:0] duty_act_i,
  input logic [NUM_CH-1:0]       pwm_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r7_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> pwm_i == '0);

  a_r7_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_i == '0);

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |->
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

  a_r9_ps_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && ps_act_i != $past(ps_act_i)) |-> cnt_i == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r6_rise_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_i[c]) |-> cnt_i == '0);

    a_r5_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && duty_act_i[c*CNT_W +: CNT_W] == CNT_MAX) |-> pwm_i[c]);

    a_r8_duty_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && $past(active_i) &&
       duty_act_i[c*CNT_W +: CNT_W] != $past(duty_act_i[c*CNT_W +: CNT_W]))
        |-> cnt_i == '0);
  end
endmodule

bind pwm_bank_top pwm_bank_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .PS_W   (pwm_bank_pkg::PS_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (run_en),
  .active_i   (active),
  .cnt_i      (cnt),
  .ps_act_i   (ps_act),
  .duty_act_i (duty_act),
  .pwm_i      (pwm_o)
);

// File: tb/pwm_bank_top_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_top_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int rises   [NCH];
  int hi_len  [NCH];
  int per_len [NCH];
  int last_rs [NCH];
  int hi_run  [NCH];
  bit prev    [NCH];
  int base_r  [NCH];

  always #2 clk = ~clk;

  pwm_bank_top dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  initial begin
    for (int c = 0; c < NCH; c++) begin
      rises[c] = 0; hi_len[c] = 0; per_len[c] = 0;
      last_rs[c] = 0; hi_run[c] = 0; prev[c] = 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < NCH; c++) begin
      if (pwm[c] && !prev[c]) begin
        rises[c]   = rises[c] + 1;
        per_len[c] = cyc - last_rs[c];
        last_rs[c] = cyc;
        hi_run[c]  = 1;
      end else if (pwm[c]) begin
        hi_run[c] = hi_run[c] + 1;
      end
      if (!pwm[c] && prev[c]) hi_len[c] = hi_run[c];
      prev[c] = pwm[c];
    end
  end

  function automatic int exp_hi(int d, int p);
    return (d + 1) * (p + 1);
  endfunction

  function automatic int exp_per(int p);
    return 256 * (p + 1);
  endfunction

  function automatic logic [31:0] ctrl_word(bit en, int p);
    logic [7:0] ps;
    ps = 8'(p);
    return (32'(ps[7:4]) << 11) | (32'(en) << 9) | 32'(ps[3:0]);
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    step();
    d = rdata;
  endtask

  task automatic snap();
    for (int c = 0; c < NCH; c++) base_r[c] = rises[c];
  endtask

  task automatic wait_n(bit [NCH-1:0] mask, int n);
    bit done;
    done = 1'b0;
    while (!done) begin
      step();
      done = 1'b1;
      for (int c = 0; c < NCH; c++)
        if (mask[c] && rises[c] < base_r[c] + n) done = 1'b0;
    end
  endtask

  task automatic run_cfg(int p, int d0, int d1, int d2, int d3, string tag);
    int d [NCH];
    bit [NCH-1:0] mask;
    int ref_c;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    wr(8'h50, 32'h0);
    for (int c = 0; c < NCH; c++) wr(8'(4 * c), 32'(d[c]));
    mask = '0;
    ref_c = -1;
    for (int c = 0; c < NCH; c++) if (d[c] < 255) begin
      mask[c] = 1'b1;
      if (ref_c < 0) ref_c = c;
    end
    snap();
    wr(8'h50, ctrl_word(1'b1, p));
    wait_n(mask, 3);
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        chk(per_len[c] == exp_per(p), {"R3 period ", tag}, per_len[c], exp_per(p));
        chk(hi_len[c] == exp_hi(d[c], p), {"R4 high ", tag}, hi_len[c], exp_hi(d[c], p));
        chk(last_rs[c] == last_rs[ref_c], {"R6 aligned rise ", tag}, last_rs[c], last_rs[ref_c]);
      end else begin
        chk(pwm[c] == 1'b1, {"R5 full high ", tag}, int'(pwm[c]), 1);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p, d0, d1, d2, d3;
    void'($urandom(32'd4711));
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(pwm == '0, "R1 pins after reset", int'(pwm), 0);
    for (int c = 0; c < NCH; c++) begin
      rd(8'(4 * c), v);
      chk(v == 32'h0, "R1 duty reset", int'(v), 0);
    end
    rd(8'h50, v);
    chk(v == 32'h0, "R1 ctrl reset", int'(v), 0);

    // R2 register map and masking
    wr(8'h00, 32'h1234_56AB);
    rd(8'h00, v);
    chk(v == 32'h0000_00AB, "R2 duty mask", int'(v), 32'hAB);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, v);
    chk(v == 32'h0000_7A0F, "R2 ctrl fields", int'(v), 32'h7A0F);
    wr(8'h50, 32'h0);
    rd(8'h40, v);
    chk(v == 32'h0, "R2 unmapped", int'(v), 0);
    rd(8'h10, v);
    chk(v == 32'h0, "R2 beyond channels", int'(v), 0);

    // R7 start and stop timing
    wr(8'h00, 32'd3);
    wr(8'h50, ctrl_word(1'b1, 0));
    chk(pwm[0] == 1'b0, "R7 low right after enable edge", int'(pwm[0]), 0);
    step();
    chk(pwm[0] == 1'b1, "R7 high one edge later", int'(pwm[0]), 1);
    repeat (20) step();
    wr(8'h50, 32'h0);
    chk(pwm == '0, "R7 low after disable", int'(pwm), 0);
    begin
      bit stay_low;
      stay_low = 1'b1;
      for (int i = 0; i < 30; i++) begin
        step();
        if (pwm != '0) stay_low = 1'b0;
      end
      chk(stay_low, "R7 held low while disabled", int'(stay_low), 1);
    end

    // Directed corners: duty 0, duty 255, high prescale nibble
    run_cfg(0, 0, 128, 255, 254, "d0/d255");
    run_cfg(16, 7, 0, 255, 40, "ps hi nibble");

    // Constrained random configurations
    for (int t = 0; t < 6; t++) begin
      p  = int'($urandom_range(2, 0));
      d0 = int'($urandom_range(254, 0));
      d1 = int'($urandom_range(254, 0));
      d2 = int'($urandom_range(254, 0));
      d3 = int'($urandom_range(254, 0));
      run_cfg(p, d0, d1, d2, d3, "random");
    end

    // R8 duty write mid-period
    wr(8'h50, 32'h0);
    wr(8'h00, 32'd100);
    snap();
    wr(8'h50, ctrl_word(1'b1, 0));
    wait_n(4'b0001, 1);
    repeat (9) step();
    wr(8'h00, 32'd20);
    wait_n(4'b0001, 2);
    chk(hi_len[0] == 101, "R8 mid write keeps old pulse", hi_len[0], 101);
    wait_n(4'b0001, 3);
    chk(hi_len[0] == 21, "R8 new pulse next period", hi_len[0], 21);

    // R8 duty write landing on the wrap edge
    wait_n(4'b0001, 4);
    repeat (255) step();
    wr(8'h00, 32'd60);
    wait_n(4'b0001, 6);
    chk(hi_len[0] == 21, "R8 wrap-edge write keeps old pulse", hi_len[0], 21);
    wait_n(4'b0001, 7);
    chk(hi_len[0] == 61, "R8 wrap-edge write applies later", hi_len[0], 61);

    // R9 prescale write mid-period
    wr(8'h00, 32'd100);
    wait_n(4'b0001, 9);
    repeat (5) step();
    wr(8'h50, ctrl_word(1'b1, 1));
    wait_n(4'b0001, 10);
    chk(per_len[0] == 256, "R9 current period keeps old length", per_len[0], 256);
    wait_n(4'b0001, 11);
    chk(per_len[0] == 512, "R9 new period length", per_len[0], 512);
    chk(hi_len[0] == 202, "R9 new pulse scaled", hi_len[0], 202);

    wr(8'h50, 32'h0);
    step();
    summary();
    $finish;
  end
endmodule